// File: doc/BRIEF.md
# Control and Status Register Slave

This block is a bus slave holding a bank of writable control words and a bank of read-only status words, all 32 bits wide. The control bank has 2^CTRL_AW entries and the status bank has 2^STAT_AW entries. Both banks share one address space, and a single address bit selects the bank. Every control word is driven continuously on a wide parallel output so that surrounding logic can use it. Every status word is taken from a wide parallel input at the moment a read is accepted.

A master starts an access by raising the strobe, with the address, the write flag and the write data. It holds these until the slave answers with a one-cycle acknowledge or a one-cycle error. Read data is valid only in the response cycle and is zero at all other times. An address that decodes to no register gets an error response instead of an acknowledge, and no register changes.

Top module: `csr_slave`

## Requirements
- R1: While reset is high, and in the cycle after it, every control word on `ctrl_q` is zero and both `bus_ack` and `bus_err` are low.
- R2: A write to control index i stores `bus_wdata` in word i only. `ctrl_q[32*i +: 32]` shows the new value in the same cycle as the acknowledge, and every other word keeps its value.
- R3: A read of control index i returns the stored word on `bus_rdata` in the acknowledge cycle. For example, a read after writing 0xDEADBEEF to index 0 returns 0xDEADBEEF.
- R4: A read of status index j returns `stat_d[32*j +: 32]`, sampled at the clock edge where the access is accepted.
- R5: Address bit SEL = max(CTRL_AW, STAT_AW) selects the bank, 0 for control and 1 for status. The control or status index is taken from bits SEL-1..0.
- R6: A write to a valid status address is acknowledged and has no effect on any control word.
- R7: An address with any bit above SEL set, or whose index is at or beyond the size of the selected bank, gets a one-cycle `bus_err` with no `bus_ack`. A write to such an address changes nothing.
- R8: Each accepted access produces exactly one response cycle. `bus_ack` is never high in two consecutive cycles, so a strobe held high gives one response in every second cycle.
- R9: `bus_ack` and `bus_err` are never high together. `bus_rdata` is zero whenever no read acknowledge is being given.
- R10: Without a strobe no response is produced and `ctrl_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | BUS_AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_stb | input | 1 | Access request, held until the response |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle acknowledge of a valid access |
| bus_err | output | 1 | One-cycle response to an undecoded address |
| ctrl_q | output | 32*2^CTRL_AW | All control words, word i at bits 32*i+31..32*i |
| stat_d | input | 32*2^STAT_AW | All status words, word j at bits 32*j+31..32*j |

## Verification
Every response arrives at the first rising edge at which the slave sees the strobe while not already responding. That edge also updates the addressed control word, so `ctrl_q`, `bus_rdata`, `bus_ack` and `bus_err` are all due one edge after an idle-state strobe. The bench raises the strobe on a falling edge and samples one nanosecond after each rising edge until a response appears, which tolerates the one dead cycle that follows the previous answer. The held-strobe scenario counts responses over six edges and expects them on the 1st, 3rd and 5th edges.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int WORD_W = 32;

  typedef enum logic {BANK_CTRL = 1'b0, BANK_STAT = 1'b1} bank_e;

  // Bank select position: one above the wider of the two index fields.
  function automatic int sel_bit(input int ctrl_aw, input int stat_aw);
    return (ctrl_aw > stat_aw) ? ctrl_aw : stat_aw;
  endfunction

  // Index field width, never zero so vectors stay legal.
  function automatic int idx_width(input int sel);
    return (sel < 1) ? 1 : sel;
  endfunction

  // True when an index lies inside a bank of the given entry count.
  function automatic logic idx_in_bank(input longint unsigned idx, input longint unsigned entries);
    return idx < entries;
  endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int BUS_AW  = 32,
  parameter int CTRL_AW = 2,
  parameter int STAT_AW = 1,
  localparam int SEL    = sel_bit(CTRL_AW, STAT_AW),
  localparam int IDX_W  = idx_width(SEL),
  localparam int NCTRL  = 1 << CTRL_AW,
  localparam int NSTAT  = 1 << STAT_AW
) (
  input  logic [BUS_AW-1:0] addr,
  output bank_e             bank,
  output logic [IDX_W-1:0]  idx,
  output logic              ok
);
  logic [BUS_AW-1:0] low_mask;
  logic [BUS_AW-1:0] idx_full;
  logic [BUS_AW-1:0] upper;
  logic              in_range;

  always_comb begin
    low_mask = (BUS_AW'(1) << SEL) - BUS_AW'(1);
    idx_full = addr & low_mask;
    upper    = addr >> (SEL + 1);
    bank     = bank_e'(addr[SEL]);
    idx      = idx_full[IDX_W-1:0];
    if (bank == BANK_CTRL)
      in_range = idx_in_bank(longint'(idx_full), longint'(NCTRL));
    else
      in_range = idx_in_bank(longint'(idx_full), longint'(NSTAT));
    ok = (upper == '0) && in_range;
  end
endmodule

// File: rtl/csr_ctrl_bank.sv
module csr_ctrl_bank
  import csr_pkg::*;
#(
  parameter int NCTRL = 4,
  parameter int IDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       wdata,
  output logic [NCTRL*WORD_W-1:0] q_flat,
  output logic [WORD_W-1:0]       rd_word
);
  logic [WORD_W-1:0] regs [NCTRL];

  for (genvar i = 0; i < NCTRL; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_en && (int'(idx) == i))
        regs[i] <= wdata;
    end
    assign q_flat[i*WORD_W +: WORD_W] = regs[i];
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NCTRL; k++)
      if (int'(idx) == k) rd_word = regs[k];
  end
endmodule

// File: rtl/csr_stat_mux.sv
module csr_stat_mux
  import csr_pkg::*;
#(
  parameter int NSTAT = 2,
  parameter int IDX_W = 2
) (
  input  logic [NSTAT*WORD_W-1:0] d_flat,
  input  logic [IDX_W-1:0]        idx,
  output logic [WORD_W-1:0]       rd_word
);
  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NSTAT; k++)
      if (int'(idx) == k) rd_word = d_flat[k*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/csr_slave.sv
module csr_slave
  import csr_pkg::*;
#(
  parameter int BUS_AW  = 32,
  parameter int CTRL_AW = 2,
  parameter int STAT_AW = 1,
  localparam int NCTRL  = 1 << CTRL_AW,
  localparam int NSTAT  = 1 << STAT_AW,
  localparam int SEL    = sel_bit(CTRL_AW, STAT_AW),
  localparam int IDX_W  = idx_width(SEL)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BUS_AW-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  input  logic                    bus_stb,
  input  logic                    bus_we,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    bus_ack,
  output logic                    bus_err,
  output logic [NCTRL*WORD_W-1:0] ctrl_q,
  input  logic [NSTAT*WORD_W-1:0] stat_d
);
  // Named internal events, also used by the checker.
  bank_e             dec_bank;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_ok;
  logic              resp_q;
  logic              acc_fire;
  logic              ctrl_wr;
  logic [WORD_W-1:0] ctrl_word;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] sel_word;

  csr_decode #(.BUS_AW(BUS_AW), .CTRL_AW(CTRL_AW), .STAT_AW(STAT_AW)) u_dec (
    .addr(bus_addr), .bank(dec_bank), .idx(dec_idx), .ok(dec_ok)
  );

  // One access is accepted per idle cycle; the response cycle blocks re-acceptance.
  assign acc_fire = bus_stb && !resp_q;
  assign ctrl_wr  = acc_fire && dec_ok && bus_we && (dec_bank == BANK_CTRL);

  csr_ctrl_bank #(.NCTRL(NCTRL), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .idx(dec_idx),
    .wdata(bus_wdata), .q_flat(ctrl_q), .rd_word(ctrl_word)
  );

  csr_stat_mux #(.NSTAT(NSTAT), .IDX_W(IDX_W)) u_stat (
    .d_flat(stat_d), .idx(dec_idx), .rd_word(stat_word)
  );

  assign sel_word = (dec_bank == BANK_CTRL) ? ctrl_word : stat_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q    <= 1'b0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      resp_q    <= acc_fire;
      bus_ack   <= acc_fire && dec_ok;
      bus_err   <= acc_fire && !dec_ok;
      bus_rdata <= (acc_fire && dec_ok && !bus_we) ? sel_word : '0;
    end
  end
endmodule

// File: rtl/csr_slave_chk.sv
module csr_slave_chk #(
  parameter int NCTRL = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_stb,
  input logic                  bus_we,
  input logic                  bus_ack,
  input logic                  bus_err,
  input logic [31:0]           bus_rdata,
  input logic [NCTRL*32-1:0]   ctrl_q,
  input logic                  acc_fire,
  input logic                  dec_ok,
  input logic                  dec_bank,
  input logic                  ctrl_wr
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0) && !bus_ack && !bus_err);

  assert_stat_write_noeffect_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && dec_ok && bus_we && dec_bank) |=> $stable(ctrl_q) && bus_ack);

  assert_bad_addr_err_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && !dec_ok) |=> bus_err && !bus_ack && $stable(ctrl_q));

  assert_single_ack_R8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  assert_ack_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && bus_err));

  assert_rdata_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_ack || bus_err) |-> (bus_rdata == '0));

  assert_no_stb_no_resp_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_stb |=> !bus_ack && !bus_err);

  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(ctrl_q));
endmodule

bind csr_slave csr_slave_chk #(.NCTRL(NCTRL)) u_chk (
  .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_we(bus_we),
  .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
  .ctrl_q(ctrl_q), .acc_fire(acc_fire), .dec_ok(dec_ok),
  .dec_bank(dec_bank), .ctrl_wr(ctrl_wr)
);

// File: tb/csr_slave_bench.sv
`timescale 1ns/1ps
module csr_slave_bench;
  localparam int NC = 4;
  localparam int NS = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [31:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_stb = 1'b0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_rdata;
  logic              bus_ack;
  logic              bus_err;
  logic [NC*32-1:0]  ctrl_q;
  logic [NS*32-1:0]  stat_d = {32'h0123_4567, 32'hABCD_FEDC};

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [NC];

  always #2.5 clk = ~clk;

  csr_slave #(.BUS_AW(32), .CTRL_AW(2), .STAT_AW(1)) u_csr_slave (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .ctrl_q(ctrl_q), .stat_d(stat_d)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all_ctrl(input string req);
    for (int i = 0; i < NC; i++) chk(req, ctrl_q[i*32 +: 32], model[i]);
  endtask

  task automatic access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                        output logic [31:0] rd, output logic ak, output logic er);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd; bus_stb = 1'b1;
    rd = '0; ak = 1'b0; er = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      if (bus_ack || bus_err) begin
        rd = bus_rdata; ak = bus_ack; er = bus_err;
        break;
      end
    end
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NC; i++) model[i] = '0;
    chk("R1 ctrl zero", ctrl_q[31:0] | ctrl_q[63:32] | ctrl_q[95:64] | ctrl_q[127:96], 32'h0);
    chk("R1 ack low", {31'b0, bus_ack}, 32'h0);
    chk("R1 err low", {31'b0, bus_err}, 32'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] rd; logic ak, er;
    access(32'h0, 1'b1, 32'hDEAD_BEEF, rd, ak, er);
    model[0] = 32'hDEAD_BEEF;
    chk("R2 write ack", {31'b0, ak}, 32'h1);
    chk("R2 ctrl_q at ack", ctrl_q[31:0], 32'hDEAD_BEEF);
    chk_all_ctrl("R2 others kept");
    access(32'h0, 1'b0, 32'h0, rd, ak, er);
    chk("R3 readback", rd, 32'hDEAD_BEEF);
    for (int i = 1; i < NC; i++) begin
      access(32'(i), 1'b1, 32'h1111_0000 + 32'(i), rd, ak, er);
      model[i] = 32'h1111_0000 + 32'(i);
      chk_all_ctrl("R2 per index");
    end
    for (int i = 0; i < NC; i++) begin
      access(32'(i), 1'b0, 32'h0, rd, ak, er);
      chk("R3 read each", rd, model[i]);
      chk("R5 ctrl bank ack", {31'b0, ak}, 32'h1);
    end
  endtask

  task automatic t_status();
    logic [31:0] rd; logic ak, er;
    access(32'h4, 1'b0, 32'h0, rd, ak, er);
    chk("R4 status 0", rd, 32'hABCD_FEDC);
    access(32'h5, 1'b0, 32'h0, rd, ak, er);
    chk("R4 status 1", rd, 32'h0123_4567);
    stat_d[31:0] = 32'h5A5A_0F0F;
    access(32'h4, 1'b0, 32'h0, rd, ak, er);
    chk("R4 status follows input", rd, 32'h5A5A_0F0F);
    access(32'h4, 1'b1, 32'hFFFF_FFFF, rd, ak, er);
    chk("R6 status write ack", {31'b0, ak}, 32'h1);
    chk_all_ctrl("R6 status write no effect");
  endtask

  task automatic t_bad_addr();
    logic [31:0] rd; logic ak, er;
    access(32'h6, 1'b0, 32'h0, rd, ak, er);
    chk("R7 status index out of bank err", {31'b0, er}, 32'h1);
    chk("R7 no ack", {31'b0, ak}, 32'h0);
    chk("R9 rdata zero on err", rd, 32'h0);
    access(32'h100, 1'b1, 32'hCAFE_CAFE, rd, ak, er);
    chk("R7 upper bits err", {31'b0, er}, 32'h1);
    chk_all_ctrl("R7 bad write ignored");
    access(32'h9, 1'b1, 32'hCAFE_CAFE, rd, ak, er);
    chk("R5 bit above select err", {31'b0, er}, 32'h1);
    chk_all_ctrl("R7 aliased write ignored");
  endtask

  task automatic t_held_strobe();
    int acks = 0; logic prev = 1'b0; int dbl = 0;
    repeat (2) @(negedge clk);
    bus_addr = 32'h1; bus_we = 1'b0; bus_stb = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      if (bus_ack) acks++;
      if (bus_ack && prev) dbl++;
      prev = bus_ack;
    end
    bus_stb = 1'b0;
    chk("R8 held strobe responses", 32'(acks), 32'd3);
    chk("R8 no back to back ack", 32'(dbl), 32'd0);
  endtask

  task automatic t_idle();
    int resp = 0;
    repeat (2) @(negedge clk);
    bus_wdata = 32'h7777_7777; bus_we = 1'b1; bus_addr = 32'h2;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      if (bus_ack || bus_err) resp++;
      chk("R9 rdata idle", bus_rdata, 32'h0);
    end
    bus_we = 1'b0;
    chk("R10 no response without strobe", 32'(resp), 32'd0);
    chk_all_ctrl("R10 ctrl unchanged");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset();
    t_ctrl_rw();
    t_status();
    t_bad_addr();
    t_held_strobe();
    t_idle();
    t_reset();
    chk_all_ctrl("R1 reset clears after use");
    summary();
  end
endmodule